// File: doc/BRIEF.md
# Supply Undervoltage Monitor Controller

This block is the digital side of a supply-voltage watchdog. Two analog comparators feed it. One says the supply has fallen to or below a lower trip level. The other says the supply has risen above a higher recovery level. Both comparator outputs are asynchronous, so the block synchronises them. It then keeps a latched "undervoltage" condition that is set by the lower comparator and cleared only by the higher one. The gap between the two levels gives hysteresis, so a supply that hovers near the lower level cannot make reset chatter.

Configuration inputs set how the block behaves:
- Power-down switches the whole monitor off.
- Reset-disable turns it into a flag that software polls, with no reset.
- Stop-enable chooses whether the monitor stays alive during stop mode.
- A range bit is passed straight through to the analog side to pick the threshold pair.

With power-down and reset-disable both cleared, the block drives a registered reset request to the system reset controller. The latched condition can be read as the top bit of an 8-bit read-only status byte.

Top module: `lvmon_ctrl`

## Requirements
- R1: While `cfg_pwrdn_i` is 1, `low_flag_o` and `rst_req_o` are 0 from the clock edge after it is sampled, and no new trip is taken.
- R2: While `cfg_rstdis_i` is 1, `rst_req_o` is 0 from the next clock edge. `low_flag_o` still follows the trip condition.
- R3: With the monitor active and reset-disable 0, a rise of `cmp_low_i` makes `low_flag_o` and `rst_req_o` go high on the third rising clock edge after the change (two synchroniser stages plus the latch). Both are still 0 after the second edge.
- R4: Once set, `low_flag_o` and `rst_req_o` clear on the third rising edge after `cmp_recover_i` goes to 1.
- R5: If `cmp_low_i` returns to 0 while `cmp_recover_i` stays 0, the flag and the reset request stay asserted (hysteresis).
- R6: `reg_rdata_o` carries the flag in bit 7 and 0 in bits 6..0 while `reg_rd_i` is 1. It is 0x00 while `reg_rd_i` is 0. The register has no write path, and it reads 0x00 after reset.
- R7: While `stop_mode_i` is 1 and `cfg_stop_en_i` is 0, the flag and reset request are 0 from the next edge, and no new trip is taken.
- R8: While `stop_mode_i` is 1 and `cfg_stop_en_i` is 1, the monitor trips exactly as in run mode.
- R9: `range_sel_o` equals `cfg_range_i` combinationally and does not affect the sequencing.
- R10: After `rst_n` is released, `low_flag_o`, `rst_req_o` and `reg_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_low_i | input | 1 | Async comparator: supply at or below the lower trip level |
| cmp_recover_i | input | 1 | Async comparator: supply above the higher recovery level |
| cfg_pwrdn_i | input | 1 | 1 turns the monitor off |
| cfg_rstdis_i | input | 1 | 1 gives poll-only operation (no reset request) |
| cfg_stop_en_i | input | 1 | 1 keeps the monitor active in stop mode |
| cfg_range_i | input | 1 | Threshold-pair select for the analog side |
| stop_mode_i | input | 1 | Chip is in stop mode |
| reg_rd_i | input | 1 | Status register read strobe |
| reg_rdata_o | output | 8 | Status register read data |
| low_flag_o | output | 1 | Latched undervoltage flag |
| rst_req_o | output | 1 | Registered system reset request |
| range_sel_o | output | 1 | Threshold-pair select to the comparators |

## Verification
A comparator change reaches the outputs on the third rising edge after it: two edges go to synchronisation and one to the latch. The bench drives on falling edges and samples on the falling edge after the expected rising edge. It also samples one edge early to confirm that nothing has moved yet. Configuration effects (power-down, stop gating, reset-disable) take one edge, and the bench samples right after that edge. The read data and the range select are combinational, so they are checked in the same half-cycle as their inputs. The bench sweeps all sixteen combinations of power-down, reset-disable, stop mode and stop-enable through a trip, a hysteresis hold and a recovery.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
   typedef struct packed {
      logic pwrdn;
      logic rstdis;
      logic stop_en;
   } lvmon_cfg_t;

   function automatic logic lvmon_active(input lvmon_cfg_t c, input logic stop);
      return !c.pwrdn && !(stop && !c.stop_en);
   endfunction
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q[0] <= d_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q[g] <= 1'b0;
         else        chain_q[g] <= chain_q[g-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvmon_trip_core.sv
module lvmon_trip_core (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic rstdis_i,
   input  logic low_s_i,
   input  logic recover_s_i,
   output logic trip_o,
   output logic rst_req_o
);
   logic trip_q, trip_d, rst_q;

   always_comb begin
      trip_d = trip_q;
      if (!active_i)                 trip_d = 1'b0;
      else if (!trip_q && low_s_i)    trip_d = 1'b1;
      else if (trip_q && recover_s_i) trip_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trip_q <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         trip_q <= trip_d;
         rst_q  <= trip_d && !rstdis_i;
      end
   end

   assign trip_o    = trip_q;
   assign rst_req_o = rst_q;
endmodule

// File: rtl/lvmon_stat_port.sv
module lvmon_stat_port #(
   parameter int DATA_W   = 8,
   parameter int FLAG_BIT = DATA_W - 1
) (
   input  logic              rd_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o
);
   always_comb begin
      rdata_o = '0;
      if (rd_i) rdata_o[FLAG_BIT] = flag_i;
   end
endmodule

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int FLAG_BIT    = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_low_i,
   input  logic              cmp_recover_i,
   input  logic              cfg_pwrdn_i,
   input  logic              cfg_rstdis_i,
   input  logic              cfg_stop_en_i,
   input  logic              cfg_range_i,
   input  logic              stop_mode_i,
   input  logic              reg_rd_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              low_flag_o,
   output logic              rst_req_o,
   output logic              range_sel_o
);
   import lvmon_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lvmon_ctrl: SYNC_STAGES must be at least 2");
   end
   if (FLAG_BIT >= DATA_W || FLAG_BIT < 0) begin : g_bad_flag
      $error("lvmon_ctrl: FLAG_BIT out of range");
   end

   lvmon_cfg_t cfg;
   logic       low_s, rise_s, active;

   assign cfg.pwrdn   = cfg_pwrdn_i;
   assign cfg.rstdis  = cfg_rstdis_i;
   assign cfg.stop_en = cfg_stop_en_i;
   assign active      = lvmon_active(cfg, stop_mode_i);

   lvmon_sync #(.STAGES(SYNC_STAGES)) i_sync_low (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_low_i), .q_o(low_s));
   lvmon_sync #(.STAGES(SYNC_STAGES)) i_sync_rise (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_recover_i), .q_o(rise_s));

   lvmon_trip_core i_core (
      .clk(clk), .rst_n(rst_n), .active_i(active), .rstdis_i(cfg.rstdis),
      .low_s_i(low_s), .recover_s_i(rise_s),
      .trip_o(low_flag_o), .rst_req_o(rst_req_o));

   lvmon_stat_port #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) i_stat (
      .rd_i(reg_rd_i), .flag_i(low_flag_o), .rdata_o(reg_rdata_o));

   assign range_sel_o = cfg_range_i;
endmodule

// File: rtl/lvmon_ctrl_chk.sv
module lvmon_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise_s,
   input logic              cfg_pwrdn_i,
   input logic              cfg_rstdis_i,
   input logic              cfg_stop_en_i,
   input logic              cfg_range_i,
   input logic              stop_mode_i,
   input logic              reg_rd_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              low_flag_o,
   input logic              rst_req_o,
   input logic              range_sel_o
);
   AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pwrdn_i |=> (!low_flag_o && !rst_req_o)); // R1
   AST_RSTDIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rstdis_i |=> !rst_req_o); // R2
   AST_REQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> low_flag_o); // R3
   AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (low_flag_o && !rise_s && !cfg_pwrdn_i && !(stop_mode_i && !cfg_stop_en_i))
      |=> low_flag_o); // R5
   AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[DATA_W-2:0] == '0); // R6
   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |-> reg_rdata_o == '0); // R6
   AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode_i && !cfg_stop_en_i) |=> (!low_flag_o && !rst_req_o)); // R7
   AST_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      range_sel_o == cfg_range_i); // R9
endmodule

bind lvmon_ctrl lvmon_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .rise_s(rise_s),
   .cfg_pwrdn_i(cfg_pwrdn_i), .cfg_rstdis_i(cfg_rstdis_i),
   .cfg_stop_en_i(cfg_stop_en_i), .cfg_range_i(cfg_range_i),
   .stop_mode_i(stop_mode_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
   .low_flag_o(low_flag_o), .rst_req_o(rst_req_o), .range_sel_o(range_sel_o));

// File: tb/test_lvmon_ctrl.sv
module test_lvmon_ctrl;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_low = 1'b0, cmp_rec = 1'b0;
   logic       pwrdn = 1'b0, rstdis = 1'b0, stop_en = 1'b0, range_b = 1'b0;
   logic       stop_m = 1'b0, rd = 1'b0;
   logic [7:0] rdata;
   logic       flag, rreq, rsel;
   int         n_chk = 0, n_fail = 0;
   bit         done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvmon_ctrl i_lvmon_ctrl (
      .clk(clk), .rst_n(rst_n), .cmp_low_i(cmp_low), .cmp_recover_i(cmp_rec),
      .cfg_pwrdn_i(pwrdn), .cfg_rstdis_i(rstdis), .cfg_stop_en_i(stop_en),
      .cfg_range_i(range_b), .stop_mode_i(stop_m), .reg_rd_i(rd),
      .reg_rdata_o(rdata), .low_flag_o(flag), .rst_req_o(rreq), .range_sel_o(rsel));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_outs(input string req, input logic ef, input logic er);
      rd = 1'b1; #1;
      chk({req, " flag"}, {7'b0, flag}, {7'b0, ef});
      chk({req, " rst_req"}, {7'b0, rreq}, {7'b0, er});
      chk({req, " rdata"}, rdata, {ef, 7'b0});
      rd = 1'b0; #1;
      chk({req, " rdata idle"}, rdata, 8'h00);
   endtask

   task automatic clear_trip();
      pwrdn = 0; stop_m = 0; cmp_low = 0; cmp_rec = 1;
      edges(4);
      cmp_rec = 0;
      edges(3);
   endtask

   initial begin
      @(negedge clk);
      edges(2);
      rst_n = 1'b1;
      edges(1);
      check_outs("R10", 1'b0, 1'b0);

      // R9 range passthrough, both values
      for (int v = 0; v < 2; v++) begin
         range_b = v[0]; #1;
         chk("R9 range", {7'b0, rsel}, {7'b0, v[0]});
      end

      // R3 latency: nothing after two edges, asserted after third
      cmp_low = 1;
      edges(2);
      check_outs("R3 early", 1'b0, 1'b0);
      edges(1);
      check_outs("R3 trip", 1'b1, 1'b1);
      // R5 hold after falling comparator releases
      cmp_low = 0;
      edges(5);
      check_outs("R5 hold", 1'b1, 1'b1);
      // R2 reset-disable while tripped: request drops next edge, flag stays
      rstdis = 1;
      edges(1);
      check_outs("R2 drop", 1'b1, 1'b0);
      rstdis = 0;
      edges(1);
      check_outs("R2 restore", 1'b1, 1'b1);
      // R4 recovery latency
      cmp_rec = 1;
      edges(2);
      check_outs("R4 early", 1'b1, 1'b1);
      edges(1);
      check_outs("R4 clear", 1'b0, 1'b0);
      cmp_rec = 0;
      edges(3);
      // R1 power-down while tripped
      cmp_low = 1;
      edges(3);
      pwrdn = 1;
      edges(1);
      check_outs("R1 pwrdn", 1'b0, 1'b0);
      clear_trip();

      // Sweep over pwrdn, rstdis, stop mode, stop enable
      for (int k = 0; k < 16; k++) begin
         logic act, ef, er;
         string tag;
         pwrdn = k[0]; rstdis = k[1]; stop_m = k[2]; stop_en = k[3];
         act = !k[0] && !(k[2] && !k[3]);
         ef = act; er = act && !k[1];
         tag = k[0] ? "R1" : (k[2] && !k[3]) ? "R7" : k[2] ? "R8" : k[1] ? "R2" : "R3";
         cmp_low = 1; cmp_rec = 0;
         edges(4);
         check_outs({tag, " sweep trip"}, ef, er);
         cmp_low = 0;
         edges(4);
         check_outs({"R5 sweep hold/", tag}, ef, er);
         cmp_rec = 1;
         edges(4);
         check_outs({"R4 sweep recover/", tag}, 1'b0, 1'b0);
         cmp_rec = 0;
         edges(2);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule